// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a synchronous single-port static memory. Address and control are registered on every enabled rising clock edge. The data movement for that operation takes place two enabled edges later, for reads and for writes alike. Because write data trails its address by the same distance as read data, a controller can issue reads and writes in any mix on consecutive cycles without leaving the shared data bus idle when its direction changes.

A load cycle presents a fresh address and a direction. An advance cycle continues the current burst through an internal two-bit counter. The burst walks four words in either linear or interleaved order and wraps around within its four-word group. Three chip selects gate the start of new work. An active-low clock enable freezes the whole pipeline. An asynchronous output enable can pull the data drivers off at any moment. Each 36-bit word is split into four 9-bit lanes that can be written on their own. The depth is set by an address-width parameter.

Top module: `zbt_burst_sram`

## Requirements
- R1: An operation loaded at enabled edge E0 moves its data at the second enabled edge after it (E2). For a write, `dq_in` is sampled at E2. For a read, `dq_out` holds the addressed word and `dq_oe` is high from just after E2 until the next enabled edge.
- R2: Reads and writes may follow each other on consecutive enabled cycles in any order. A read issued on the cycle right after a write to the same address returns the newly written word.
- R3: While `clk_en_n` is high at an edge, all other synchronous inputs are ignored. Every register, including both pipeline stages, the burst state, `dq_out` and the internal drive flag, keeps its value.
- R4: A load cycle (`adv`=0) that is not selected starts no operation. A cycle is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Operations already in the pipeline still complete, and the data phase of the unselected slot leaves `dq_oe` low. An advance cycle after an unselected load also starts nothing.
- R5: `dq_oe` is low in the data phase of every write.
- R6: With `order_il`=0 at the load, the k-th word of a burst (k=0..3) uses low address bits (start+k) mod 4.
- R7: With `order_il`=1 at the load, the k-th word uses low address bits start XOR k. Address bits above bit 1 never change within a burst.
- R8: `lane_we_n[i]`=0, sampled with the address, lets a write update bits [9i+8:9i]. A lane with `lane_we_n[i]`=1 keeps its old contents.
- R9: `oe_n`=1 forces `dq_oe` low at once, without waiting for a clock. Returning `oe_n` to 0 restores the pipeline's drive state.
- R10: An advance cycle (`adv`=1) inherits the direction given at the load. The `rw_n` value presented on the advance cycle is ignored.
- R11: After a synchronous reset (`rst_n`=0), no operation is pending and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the pipeline and burst state |
| clk_en_n | input | 1 | Active-low clock enable; high stalls everything |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| rw_n | input | 1 | 1 = read, 0 = write (load cycles only) |
| adv | input | 1 | 0 = load new address, 1 = advance burst |
| order_il | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| lane_we_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 36 | Write data, sampled in the data phase |
| dq_out | output | 36 | Read data |
| dq_oe | output | 1 | High when the block drives the data bus |

## Verification
An internal fault here shows up on the bus exactly two enabled edges after the cycle that caused it. A mis-stepped burst counter returns a neighbouring word in place of the expected one. A lost direction bit makes `dq_oe` rise in a write slot. A stage that keeps moving during a stall shifts every later transfer by one slot. The bench checks `dq_oe` on every cycle and `dq_out` on every read slot against a reference memory, so such faults surface within three cycles of their cause. A wrong lane mask stays hidden until that word is read back, and the bench reads it back immediately.

// File: rtl/zbt_burst_sram.sv
module zbt_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              rw_n,
  input  logic              adv,
  input  logic              order_il,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic              b_act, b_wr, b_il;
  logic [ADDR_W-1:0] b_base;
  logic [1:0]        b_cnt;

  logic              p1_v, p1_w, p2_v, p2_w;
  logic [ADDR_W-1:0] p1_a, p2_a;
  logic [LANES-1:0]  p1_be, p2_be;
  logic              drive_q;
  logic [DATA_W-1:0] dout_q;

  wire              en     = !clk_en_n;
  wire              sel    = !sel_a_n && sel_b && !sel_c_n;
  wire [1:0]        nx_cnt = b_cnt + 2'd1;
  wire [1:0]        nx_lo  = b_il ? (b_base[1:0] ^ nx_cnt) : (b_base[1:0] + nx_cnt);
  wire              new_v  = adv ? b_act : sel;
  wire              new_w  = adv ? b_wr  : !rw_n;
  wire [ADDR_W-1:0] new_a  = adv ? {b_base[ADDR_W-1:2], nx_lo} : addr;
  wire              rd_now = p2_v && !p2_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_act   <= 1'b0;
      b_wr    <= 1'b0;
      b_il    <= 1'b0;
      b_base  <= '0;
      b_cnt   <= '0;
      p1_v    <= 1'b0;
      p1_w    <= 1'b0;
      p1_a    <= '0;
      p1_be   <= '1;
      p2_v    <= 1'b0;
      p2_w    <= 1'b0;
      p2_a    <= '0;
      p2_be   <= '1;
      drive_q <= 1'b0;
      dout_q  <= '0;
    end else if (en) begin
      if (!adv) begin
        b_act  <= sel;
        b_wr   <= !rw_n;
        b_il   <= order_il;
        b_base <= addr;
        b_cnt  <= '0;
      end else if (b_act) begin
        b_cnt <= nx_cnt;
      end
      p1_v    <= new_v;
      p1_w    <= new_w;
      p1_a    <= new_a;
      p1_be   <= lane_we_n;
      p2_v    <= p1_v;
      p2_w    <= p1_w;
      p2_a    <= p1_a;
      p2_be   <= p1_be;
      drive_q <= rd_now;
      if (rd_now) dout_q <= mem[p2_a];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && en && p2_v && p2_w) begin
      for (int i = 0; i < LANES; i++) begin
        if (!p2_be[i]) mem[p2_a][i*LANE_W +: LANE_W] <= dq_in[i*LANE_W +: LANE_W];
      end
    end
  end

  assign dq_out = dout_q;
  assign dq_oe  = drive_q && !oe_n;
endmodule

// File: rtl/zbt_burst_sram_chk.sv
module zbt_burst_sram_chk #(
  parameter int W = 36
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clk_en_n,
  input logic         sel_a_n,
  input logic         sel_b,
  input logic         sel_c_n,
  input logic         rw_n,
  input logic         adv,
  input logic         oe_n,
  input logic [W-1:0] dq_out,
  input logic         dq_oe
);
  logic [1:0] since;
  always_ff @(posedge clk) begin
    if (!rst_n) since <= '0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  wire en     = !clk_en_n;
  wire sel    = !sel_a_n && sel_b && !sel_c_n;
  wire ld_rd  = en && !adv && sel && rw_n;
  wire ld_wr  = en && !adv && sel && !rw_n;
  wire ld_off = en && !adv && !sel;

  a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd3 && $past(ld_rd, 3) && $past(en, 2) && $past(en, 1) && !oe_n) |-> dq_oe);

  a_r5_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd3 && $past(ld_wr, 3) && $past(en, 2) && $past(en, 1)) |-> !dq_oe);

  a_r4_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd3 && $past(ld_off, 3) && $past(en, 2) && $past(en, 1)) |-> !dq_oe);

  a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (since != 2'd0 && $past(clk_en_n)) |-> $stable(dq_out));

  a_r9_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);
endmodule

bind zbt_burst_sram zbt_burst_sram_chk #(.W(DATA_W)) u_chk (.*);

// File: tb/zbt_burst_sram_tb.sv
`timescale 1ns/1ps
module zbt_burst_sram_tb;
  localparam int AW = 6;
  localparam int DW = 36;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, clk_en_n, sel_a_n, sel_b, sel_c_n, rw_n, adv, order_il, oe_n;
  logic [3:0]    lane_we_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in, dq_out;
  logic          dq_oe;

  always #2.5 clk = ~clk;

  zbt_burst_sram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .rw_n(rw_n), .adv(adv), .order_il(order_il), .lane_we_n(lane_we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

  typedef struct {
    bit            v;
    bit            wr;
    logic [AW-1:0] a;
    logic [3:0]    be;
    string         tg;
  } op_t;

  op_t           m1, m2;
  logic [DW-1:0] ref_mem [DEPTH];
  bit            b_act, b_wr, b_il;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt;
  int            errors = 0;
  int            checks = 0;
  logic [DW-1:0] prev_out;
  logic          prev_oe;

  function automatic logic [AW-1:0] burst_addr(logic [AW-1:0] base, logic [1:0] k, bit il);
    logic [1:0] lo;
    lo = il ? (base[1:0] ^ k) : (base[1:0] + k);
    return {base[AW-1:2], lo};
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [3:0] ben);
    for (int i = 0; i < 4; i++) if (!ben[i]) old[i*9 +: 9] = nw[i*9 +: 9];
    return old;
  endfunction

  task automatic chk(string tg, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tg, act, exp);
    end
  endtask

  task automatic cyc(bit en, bit ld, bit sel, bit rd, bit il, logic [3:0] ben,
                     logic [AW-1:0] ad, string tg);
    op_t           nop;
    logic [DW-1:0] wd;
    @(negedge clk);
    clk_en_n  = !en;
    adv       = !ld;
    rw_n      = rd;
    order_il  = il;
    lane_we_n = ben;
    addr      = ad;
    if (sel) {sel_a_n, sel_b, sel_c_n} = 3'b010;
    else case ($urandom % 3)
      0:       {sel_a_n, sel_b, sel_c_n} = 3'b110;
      1:       {sel_a_n, sel_b, sel_c_n} = 3'b000;
      default: {sel_a_n, sel_b, sel_c_n} = 3'b011;
    endcase
    wd    = {4'($urandom()), $urandom()};
    dq_in = wd;
    nop.v = 1'b0; nop.wr = 1'b0; nop.a = '0; nop.be = '1; nop.tg = "R4";
    if (en) begin
      if (ld) begin
        if (sel) begin nop.v = 1'b1; nop.wr = !rd; nop.a = ad; nop.be = ben; nop.tg = tg; end
        b_act = sel; b_wr = !rd; b_base = ad; b_il = il; b_cnt = 2'd0;
      end else if (b_act) begin
        b_cnt  = b_cnt + 2'd1;
        nop.v  = 1'b1; nop.wr = b_wr; nop.a = burst_addr(b_base, b_cnt, b_il);
        nop.be = ben;  nop.tg = tg;
      end
      if (m2.v && m2.wr) ref_mem[m2.a] = merge(ref_mem[m2.a], wd, m2.be);
    end
    @(posedge clk);
    #1;
    if (!en) begin
      chk("R3 data held", dq_out, prev_out);
      chk("R3 drive held", {35'd0, dq_oe}, {35'd0, prev_oe});
    end else if (m2.v && !m2.wr) begin
      chk({m2.tg, " read drive"}, {35'd0, dq_oe}, {35'd0, !oe_n});
      chk({m2.tg, " read data"}, dq_out, ref_mem[m2.a]);
    end else if (m2.v) begin
      chk({"R5 write slot quiet (", m2.tg, ")"}, {35'd0, dq_oe}, '0);
    end else begin
      chk({m2.tg, " empty slot quiet"}, {35'd0, dq_oe}, '0);
    end
    if (en) begin m2 = m1; m1 = nop; end
    prev_out = dq_out;
    prev_oe  = dq_oe;
  endtask

  task automatic flush();
    repeat (2) cyc(1, 1, 0, 1, 0, 4'h0, '0, "R4");
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; clk_en_n = 1'b1; adv = 1'b0; rw_n = 1'b1; order_il = 1'b0; oe_n = 1'b0;
    {sel_a_n, sel_b, sel_c_n} = 3'b110; lane_we_n = '0; addr = '0; dq_in = '0;
    m1.v = 0; m1.wr = 0; m1.a = '0; m1.be = '1; m1.tg = "R11";
    m2 = m1;
    b_act = 0; b_wr = 0; b_il = 0; b_base = '0; b_cnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R11 reset drive off", {35'd0, dq_oe}, '0);
    prev_out = dq_out;
    prev_oe  = dq_oe;

    for (int a = 0; a < DEPTH; a++) cyc(1, 1, 1, 0, 0, 4'h0, AW'(a), "R1");
    flush();
    for (int a = 0; a < DEPTH; a++) cyc(1, 1, 1, 1, 0, 4'h0, AW'(a), "R1");
    flush();

    for (int i = 0; i < 16; i++) begin
      cyc(1, 1, 1, 0, 0, 4'h0, AW'(8 + i % 8), "R2");
      cyc(1, 1, 1, 1, 0, 4'h0, AW'(8 + i % 8), "R2");
    end
    flush();

    cyc(1, 1, 1, 1, 0, 4'h0, AW'(5), "R6");
    repeat (3) cyc(1, 0, 1, 0, 1, 4'h0, AW'(40), "R6");
    cyc(1, 1, 1, 1, 1, 4'h0, AW'(5), "R7");
    repeat (3) cyc(1, 0, 1, 0, 0, 4'h0, AW'(40), "R7");
    cyc(1, 1, 1, 1, 1, 4'h0, AW'(18), "R7");
    repeat (5) cyc(1, 0, 1, 0, 0, 4'h0, AW'(0), "R7");
    flush();

    cyc(1, 1, 1, 0, 0, 4'h0, AW'(21), "R10");
    repeat (3) cyc(1, 0, 1, 1, 1, 4'h0, AW'(0), "R10");
    cyc(1, 1, 1, 1, 0, 4'h0, AW'(20), "R10");
    repeat (3) cyc(1, 0, 1, 0, 0, 4'h0, AW'(0), "R10");
    flush();

    for (int b = 0; b < 16; b++) begin
      cyc(1, 1, 1, 0, 0, 4'(b), AW'(30), "R8");
      cyc(1, 1, 1, 1, 0, 4'hF, AW'(30), "R8");
    end
    flush();

    cyc(1, 1, 1, 1, 0, 4'h0, AW'(3), "R4 pending read");
    cyc(1, 1, 0, 1, 0, 4'h0, AW'(4), "R4");
    repeat (3) cyc(1, 0, 1, 1, 0, 4'h0, AW'(0), "R4");
    cyc(1, 1, 1, 0, 0, 4'h0, AW'(9), "R4 pending write");
    cyc(1, 1, 0, 1, 0, 4'h0, AW'(9), "R4");
    cyc(1, 1, 1, 1, 0, 4'h0, AW'(9), "R4");
    flush();

    cyc(1, 1, 1, 1, 0, 4'h0, AW'(11), "R3");
    cyc(1, 1, 1, 0, 0, 4'h0, AW'(12), "R3");
    for (int k = 0; k < 4; k++)
      cyc(0, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, 4'($urandom), AW'($urandom), "R3");
    cyc(1, 1, 1, 1, 0, 4'h0, AW'(12), "R3");
    cyc(0, 1, 1, 0, 0, 4'h0, AW'(13), "R3");
    cyc(1, 1, 0, 1, 0, 4'h0, AW'(0), "R3");
    cyc(0, 0, 1, 0, 0, 4'h0, AW'(14), "R3");
    flush();

    cyc(1, 1, 1, 1, 0, 4'h0, AW'(1), "R9");
    flush();
    cyc(1, 1, 0, 1, 0, 4'h0, '0, "R4");
    cyc(1, 1, 1, 1, 0, 4'h0, AW'(2), "R9");
    cyc(1, 1, 0, 1, 0, 4'h0, '0, "R4");
    cyc(1, 1, 0, 1, 0, 4'h0, '0, "R4");
    oe_n = 1'b1;
    #0.5;
    chk("R9 oe forces off", {35'd0, dq_oe}, '0);
    oe_n = 1'b0;
    #0.5;
    chk("R9 oe restores drive", {35'd0, dq_oe}, 36'd1);
    prev_oe = dq_oe;
    flush();

    for (int n = 0; n < 3000; n++) begin
      bit       en, ld, sl;
      logic [3:0] ben;
      en  = ($urandom % 5) != 0;
      ld  = ($urandom % 3) != 0;
      sl  = ($urandom % 8) != 0;
      ben = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      cyc(en, ld, sl, $urandom % 2, $urandom % 2, ben, AW'($urandom), "R2");
    end
    flush();

    summary();
    $finish;
  end
endmodule